// File: doc/BRIEF.md
# Special capability register file

This block holds the four capability-valued machine registers that a capability-aware core needs for trap handling: the trap vector, the trap data register, a scratch register and the exception program counter. It serves one access instruction that behaves like an integer CSR swap. The instruction gives a register index, a source capability and a flag that says whether the source register index is zero. The block returns the old contents of the selected register in the same cycle and, when the write is allowed, stores the new value at the next clock edge.

Values written to the trap vector and the exception PC are checked and legalised as they come in. The low address bits are forced to zero, and the stored tag is dropped when legalisation changed the address or when the value is sealed or lacks execute permission. Because of this check, the trap vector can only hold a direct-mode, word-aligned target, and a later trap or return never installs a sealed or non-executable capability. A separate trap-entry port writes the exception PC from the current PCC and the faulting address. It clears the tag when the trap is an instruction-fetch bounds fault. The block also flags any use of the legacy integer trap-vector and exception-PC CSR numbers as a reserved instruction. Capabilities cross the ports in an already-decoded form. Compression and decompression are done elsewhere.

Top module: `scr_file`

## Requirements
- R1: Access indices 28, 29, 30 and 31 select trap vector, trap data, scratch and exception PC. An enabled access to any other index raises `acc_fault` and neither reads nor writes.
- R2: When `pcc_asr` is 0, an enabled access raises `acc_fault`, drives `acc_old` to all zeros and leaves every register unchanged.
- R3: An allowed access drives `acc_old` in the same cycle with the value the register held before the access. It writes only when `acc_src_zero` is 0, and the new value is visible after the next rising clock edge. With `acc_en` at 0, `acc_old` is zero and `acc_fault` is 0.
- R4: A trap-vector write stores the source with address bits [1:0] cleared. This means only direct mode can be held. The stored tag is the source tag, cleared if either of those bits was 1, if sealed is 1, or if exec is 0.
- R5: An exception-PC write stores the source with address bit 0 cleared. The stored tag is the source tag, cleared if bit 0 was 1, if sealed is 1, or if exec is 0. Address bit 1 alone does not clear the tag.
- R6: Trap-data and scratch writes store the source bit for bit, even when it is sealed, non-executable or unaligned.
- R7: `csr_illegal` is 1 exactly when `csr_en` is 1 and `csr_num` is 0x305 (legacy trap vector) or 0x341 (legacy exception PC).
- R8: Reading the exception PC returns the stored value without any further legalisation, including an odd address left there by a trap.
- R9: When `trap_wr` is 1, the exception PC takes `pcc_cur` with its address replaced by `trap_pc`. The tag is cleared if `trap_fetch_bounds` is 1. A trap write takes priority over an access write to the exception PC in the same cycle.
- R10: Reset loads the trap vector and exception PC with the executable root (tag 1, sealed 0, exec 1, meta all ones, address 0). It loads trap data and scratch with the data root (the same but exec 0). All four values are parameters.
- R11: `tvec_o` and `epc_o` always show the stored trap vector and exception PC.
- Capability layout on every capability port (47 bits): bit 46 tag, bit 45 sealed, bit 44 exec, bits 43:32 opaque metadata, bits 31:0 address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_en | input | 1 | Access instruction valid this cycle |
| acc_idx | input | 5 | Special register index |
| acc_src_zero | input | 1 | Source register index is zero (read only) |
| pcc_asr | input | 1 | PCC grants system-register access |
| acc_src | input | 47 | Source capability |
| acc_old | output | 47 | Previous value of the selected register |
| acc_fault | output | 1 | Access exception |
| csr_en | input | 1 | Integer CSR instruction valid |
| csr_num | input | 12 | Integer CSR number |
| csr_illegal | output | 1 | Legacy CSR access, reserved instruction |
| trap_wr | input | 1 | Trap entry writes the exception PC |
| trap_pc | input | 32 | Address of the trapping instruction |
| trap_fetch_bounds | input | 1 | Trap is an instruction-fetch bounds fault |
| pcc_cur | input | 47 | Current PCC |
| tvec_o | output | 47 | Stored trap vector |
| epc_o | output | 47 | Stored exception PC |

## Verification
The hardest case to reach is an exception PC that holds a value the access port could never have written: an odd address with a valid tag. Only the trap port can leave the register in that state. The stimulus first sends a trap with an odd `trap_pc` and no bounds fault, then reads index 31. This shows that the read returns the value unlegalised. The stimulus then drives a trap and a conflicting access write in the same cycle to show that the trap wins. Each legalisation rule is also exercised at its edges: address bit 1 alone against the two trap-vector bits and the single exception-PC bit, and sealed or non-executable values with aligned addresses.

// File: rtl/scr_pkg.sv
package scr_pkg;
  parameter int ADDR_W = 32;
  parameter int META_W = 12;
  localparam int CAP_W   = ADDR_W + META_W + 3;
  localparam int NUM_SCR = 4;
  localparam int IDX_W   = 5;
  localparam int IDX_BASE = 28;
  localparam int SLOT_W  = $clog2(NUM_SCR);
  localparam int CSR_W   = 12;
  localparam int TVEC_LOW = 2;
  localparam int EPC_LOW  = 1;
  localparam logic [CSR_W-1:0] CSR_OLD_TVEC = 12'h305;
  localparam logic [CSR_W-1:0] CSR_OLD_EPC  = 12'h341;

  typedef struct packed {
    logic              tag;
    logic              sealed;
    logic              exec;
    logic [META_W-1:0] meta;
    logic [ADDR_W-1:0] addr;
  } cap_t;

  localparam int SLOT_TVEC    = 0;
  localparam int SLOT_TDATA   = 1;
  localparam int SLOT_SCRATCH = 2;
  localparam int SLOT_EPC     = 3;

  localparam cap_t ROOT_EXEC = '{tag: 1'b1, sealed: 1'b0, exec: 1'b1,
                                 meta: {META_W{1'b1}}, addr: {ADDR_W{1'b0}}};
  localparam cap_t ROOT_DATA = '{tag: 1'b1, sealed: 1'b0, exec: 1'b0,
                                 meta: {META_W{1'b1}}, addr: {ADDR_W{1'b0}}};

  // Clear the low address bits; keep the tag only for an aligned,
  // unsealed, executable source.
  function automatic cap_t f_legalise(cap_t c, int unsigned low_bits);
    logic [ADDR_W-1:0] mask;
    cap_t r;
    mask   = (ADDR_W'(1) << low_bits) - ADDR_W'(1);
    r      = c;
    r.addr = c.addr & ~mask;
    r.tag  = c.tag & ~(|(c.addr & mask)) & ~c.sealed & c.exec;
    return r;
  endfunction

  function automatic cap_t f_trap_value(cap_t pcc, logic [ADDR_W-1:0] pc,
                                        logic bounds);
    cap_t r;
    r      = pcc;
    r.addr = pc;
    r.tag  = pcc.tag & ~bounds;
    return r;
  endfunction
endpackage

// File: rtl/scr_access_decode.sv
module scr_access_decode
  import scr_pkg::*;
(
  input  logic              acc_en,
  input  logic [IDX_W-1:0]  acc_idx,
  input  logic              acc_src_zero,
  input  logic              pcc_asr,
  input  logic              csr_en,
  input  logic [CSR_W-1:0]  csr_num,
  output logic [SLOT_W-1:0] slot,
  output logic              rd_ok,
  output logic              wr_ok,
  output logic              fault,
  output logic              csr_illegal
);
  logic [IDX_W-1:0] diff;
  logic             hit;

  always_comb begin
    diff  = acc_idx - IDX_W'(IDX_BASE);
    hit   = (acc_idx >= IDX_W'(IDX_BASE)) && (diff < IDX_W'(NUM_SCR));
    slot  = diff[SLOT_W-1:0];
    fault = acc_en && (!pcc_asr || !hit);
    rd_ok = acc_en && !fault;
    wr_ok = rd_ok && !acc_src_zero;
    csr_illegal = csr_en && ((csr_num == CSR_OLD_TVEC) || (csr_num == CSR_OLD_EPC));
  end
endmodule

// File: rtl/scr_wr_legalise.sv
module scr_wr_legalise
  import scr_pkg::*;
#(
  parameter int LOW_BITS = 2
) (
  input  cap_t cap_i,
  output cap_t cap_o,
  output logic tag_dropped
);
  assign cap_o       = f_legalise(cap_i, LOW_BITS);
  assign tag_dropped = cap_i.tag && !cap_o.tag;
endmodule

// File: rtl/scr_trap_capture.sv
module scr_trap_capture
  import scr_pkg::*;
(
  input  cap_t              pcc_i,
  input  logic [ADDR_W-1:0] pc_i,
  input  logic              bounds_i,
  output cap_t              epc_o
);
  assign epc_o = f_trap_value(pcc_i, pc_i, bounds_i);
endmodule

// File: rtl/scr_file.sv
module scr_file
  import scr_pkg::*;
#(
  parameter cap_t RST_TVEC    = ROOT_EXEC,
  parameter cap_t RST_TDATA   = ROOT_DATA,
  parameter cap_t RST_SCRATCH = ROOT_DATA,
  parameter cap_t RST_EPC     = ROOT_EXEC
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_en,
  input  logic [IDX_W-1:0]  acc_idx,
  input  logic              acc_src_zero,
  input  logic              pcc_asr,
  input  logic [CAP_W-1:0]  acc_src,
  output logic [CAP_W-1:0]  acc_old,
  output logic              acc_fault,
  input  logic              csr_en,
  input  logic [CSR_W-1:0]  csr_num,
  output logic              csr_illegal,
  input  logic              trap_wr,
  input  logic [ADDR_W-1:0] trap_pc,
  input  logic              trap_fetch_bounds,
  input  logic [CAP_W-1:0]  pcc_cur,
  output logic [CAP_W-1:0]  tvec_o,
  output logic [CAP_W-1:0]  epc_o
);
  cap_t              src;
  cap_t              trap_val;
  cap_t              cur [NUM_SCR];
  logic [SLOT_W-1:0] slot;
  logic              rd_ok, wr_ok;
  logic [NUM_SCR-1:0] wr_sel;
  logic [NUM_SCR-1:0] tag_drop;
  logic [NUM_SCR*CAP_W-1:0] state_vec;

  assign src = cap_t'(acc_src);

  scr_access_decode u_dec (
    .acc_en      (acc_en),
    .acc_idx     (acc_idx),
    .acc_src_zero(acc_src_zero),
    .pcc_asr     (pcc_asr),
    .csr_en      (csr_en),
    .csr_num     (csr_num),
    .slot        (slot),
    .rd_ok       (rd_ok),
    .wr_ok       (wr_ok),
    .fault       (acc_fault),
    .csr_illegal (csr_illegal)
  );

  scr_trap_capture u_trap (
    .pcc_i   (cap_t'(pcc_cur)),
    .pc_i    (trap_pc),
    .bounds_i(trap_fetch_bounds),
    .epc_o   (trap_val)
  );

  for (genvar s = 0; s < NUM_SCR; s++) begin : g_slot
    localparam cap_t RV = (s == SLOT_TVEC)  ? RST_TVEC  :
                          (s == SLOT_TDATA) ? RST_TDATA :
                          (s == SLOT_SCRATCH) ? RST_SCRATCH : RST_EPC;
    cap_t filt;
    cap_t q;

    if (s == SLOT_TVEC) begin : g_leg
      scr_wr_legalise #(.LOW_BITS(TVEC_LOW)) u_leg (
        .cap_i(src), .cap_o(filt), .tag_dropped(tag_drop[s]));
    end else if (s == SLOT_EPC) begin : g_leg
      scr_wr_legalise #(.LOW_BITS(EPC_LOW)) u_leg (
        .cap_i(src), .cap_o(filt), .tag_dropped(tag_drop[s]));
    end else begin : g_pass
      assign filt        = src;
      assign tag_drop[s] = 1'b0;
    end

    assign wr_sel[s] = wr_ok && (slot == SLOT_W'(s));

    if (s == SLOT_EPC) begin : g_upd
      always_ff @(posedge clk) begin
        if (!rst_n)         q <= RV;
        else if (trap_wr)   q <= trap_val;
        else if (wr_sel[s]) q <= filt;
      end
    end else begin : g_upd
      always_ff @(posedge clk) begin
        if (!rst_n)         q <= RV;
        else if (wr_sel[s]) q <= filt;
      end
    end

    assign cur[s] = q;
    assign state_vec[s*CAP_W +: CAP_W] = q;
  end

  assign acc_old = rd_ok ? CAP_W'(cur[slot]) : '0;
  assign tvec_o  = cur[SLOT_TVEC];
  assign epc_o   = cur[SLOT_EPC];

  // R1: at most one register written per access
  a_r1_one_target: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wr_sel));
  // R2: denied access reads nothing
  a_r2_denied_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_en && !pcc_asr) |-> (acc_fault && acc_old == '0));
  // R2: denied access writes nothing
  a_r2_denied_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_en && !pcc_asr && !trap_wr) |=> $stable(state_vec));
  // R3: zero source index is a pure read
  a_r3_zero_src_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_en && acc_src_zero && !trap_wr) |=> $stable(state_vec));
  // R4: trap vector stored aligned
  a_r4_tvec_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    wr_sel[SLOT_TVEC] |=> (tvec_o[1:0] == 2'b00));
  // R4: sealed trap vector never keeps its tag
  a_r4_tvec_sealed_untagged: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_sel[SLOT_TVEC] && src.sealed) |=> !tvec_o[CAP_W-1]);
  // R5: exception PC written through the access port is even
  a_r5_epc_even: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_sel[SLOT_EPC] && !trap_wr) |=> !epc_o[0]);
  // R5: tag dropped when exec missing
  a_r5_epc_noexec: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_sel[SLOT_EPC] && !trap_wr && !src.exec) |=> !epc_o[CAP_W-1]);
  // R6: scratch stores the source verbatim
  a_r6_scratch_verbatim: assert property (@(posedge clk) disable iff (!rst_n)
    wr_sel[SLOT_SCRATCH] |=> (cur[SLOT_SCRATCH] == $past(src)));
  // R9: fetch bounds trap leaves an untagged exception PC
  a_r9_bounds_untag: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_wr && trap_fetch_bounds) |=> !epc_o[CAP_W-1]);
  // R9: trap address lands unchanged
  a_r9_trap_addr: assert property (@(posedge clk) disable iff (!rst_n)
    trap_wr |=> (epc_o[ADDR_W-1:0] == $past(trap_pc)));
endmodule

// File: tb/sim_scr_file.sv
module sim_scr_file;
  import scr_pkg::*;

  typedef struct {
    string            req;
    logic [CAP_W-1:0] old;
    logic             fault;
    logic             ill;
    logic [CAP_W-1:0] tv;
    logic [CAP_W-1:0] ep;
  } item_t;

  logic clk = 0, rst_n = 0;
  logic acc_en, acc_src_zero, pcc_asr, csr_en, trap_wr, trap_fetch_bounds;
  logic [IDX_W-1:0]  acc_idx;
  logic [CAP_W-1:0]  acc_src, pcc_cur, acc_old, tvec_o, epc_o;
  logic [CSR_W-1:0]  csr_num;
  logic [ADDR_W-1:0] trap_pc;
  logic acc_fault, csr_illegal;

  int total = 0, bad = 0;
  item_t q[$];
  event mon_ev;
  logic [CAP_W-1:0] mdl [NUM_SCR];

  always #10 clk = ~clk;

  scr_file u0 (.*);

  function automatic logic [CAP_W-1:0] mk(logic t, logic s, logic x,
      logic [META_W-1:0] m, logic [ADDR_W-1:0] a);
    return {t, s, x, m, a};
  endfunction

  // Independent restatement of the legalisation rule
  function automatic logic [CAP_W-1:0] leg(logic [CAP_W-1:0] c, int k);
    logic [ADDR_W-1:0] a = c[ADDR_W-1:0];
    logic ok;
    ok = ((a % (1 << k)) == 0) && !c[CAP_W-2] && c[CAP_W-3];
    return {c[CAP_W-1] & ok, c[CAP_W-2:ADDR_W], (a >> k) << k};
  endfunction

  task automatic idle();
    acc_en = 0; acc_idx = 0; acc_src_zero = 0; pcc_asr = 1; acc_src = '0;
    csr_en = 0; csr_num = 0; trap_wr = 0; trap_pc = 0; trap_fetch_bounds = 0;
    pcc_cur = mk(1, 0, 1, 12'h0A5, 32'h0);
  endtask

  task automatic chk(string req, string f, logic [CAP_W-1:0] act, logic [CAP_W-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s act=%h exp=%h", req, f, act, exp);
    end
  endtask

  // Driver: compute the expectation from the model, push, then update the model
  task automatic go(string req);
    item_t it;
    logic flt;
    int sl;
    flt = acc_en && (!pcc_asr || acc_idx < 28);
    sl  = int'(acc_idx) - 28;
    it.req   = req;
    it.fault = flt;
    it.old   = (acc_en && !flt) ? mdl[sl] : '0;
    it.ill   = csr_en && (csr_num == 12'h305 || csr_num == 12'h341);
    it.tv    = mdl[0];
    it.ep    = mdl[3];
    q.push_back(it);
    #5 ->mon_ev;
    if (acc_en && !flt && !acc_src_zero && !(trap_wr && sl == 3)) begin
      if (sl == 0)      mdl[0] = leg(acc_src, 2);
      else if (sl == 3) mdl[3] = leg(acc_src, 1);
      else              mdl[sl] = acc_src;
    end
    if (trap_wr)
      mdl[3] = {pcc_cur[CAP_W-1] & ~trap_fetch_bounds, pcc_cur[CAP_W-2:ADDR_W], trap_pc};
    @(negedge clk);
    idle();
  endtask

  task automatic acc(int idx, logic [CAP_W-1:0] v, logic z, string req);
    acc_en = 1; acc_idx = IDX_W'(idx); acc_src = v; acc_src_zero = z;
    go(req);
  endtask

  // Monitor
  initial forever begin
    item_t it;
    @(mon_ev);
    it = q.pop_front();
    chk(it.req, "acc_old", acc_old, it.old);
    chk(it.req, "acc_fault", CAP_W'(acc_fault), CAP_W'(it.fault));
    chk(it.req, "csr_illegal", CAP_W'(csr_illegal), CAP_W'(it.ill));
    chk({it.req, " R11"}, "tvec_o", tvec_o, it.tv);
    chk({it.req, " R11"}, "epc_o", epc_o, it.ep);
  end

  initial begin
    #(200000 * 20);
    total++; bad++;
    $display("FAIL watchdog act=timeout exp=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    idle();
    mdl[0] = ROOT_EXEC; mdl[1] = ROOT_DATA; mdl[2] = ROOT_DATA; mdl[3] = ROOT_EXEC;
    repeat (3) @(negedge clk);
    rst_n = 1;
    go("R10 reset state");
    // R1 R10: read every register back
    for (int i = 28; i < 32; i++) acc(i, mk(1, 0, 1, 12'h111, 32'h44), 1, "R1 R10 read");
    // R6: verbatim stores
    acc(29, mk(1, 1, 0, 12'h3C3, 32'h8000_0003), 0, "R6 tdata write");
    acc(29, '0, 1, "R6 tdata readback");
    acc(30, mk(0, 0, 1, 12'h001, 32'h0000_0001), 0, "R6 scratch write");
    acc(30, '0, 1, "R6 scratch readback");
    // R4: trap vector rules
    acc(28, mk(1, 0, 1, 12'h222, 32'h2000_0003), 0, "R4 tvec both low bits");
    acc(28, mk(1, 0, 1, 12'h222, 32'h2000_0002), 0, "R4 tvec bit1");
    acc(28, mk(1, 0, 1, 12'h222, 32'h2000_0104), 0, "R4 tvec aligned good");
    acc(28, mk(1, 1, 1, 12'h222, 32'h2000_0100), 0, "R4 tvec sealed");
    acc(28, mk(1, 0, 0, 12'h222, 32'h2000_0100), 0, "R4 tvec no exec");
    acc(28, mk(1, 0, 1, 12'h333, 32'h0000_0040), 0, "R4 tvec restore");
    // R5: exception PC rules
    acc(31, mk(1, 0, 1, 12'h444, 32'h0000_1001), 0, "R5 epc odd");
    acc(31, mk(1, 0, 1, 12'h444, 32'h0000_1002), 0, "R5 epc bit1 keeps tag");
    acc(31, mk(1, 1, 1, 12'h444, 32'h0000_1004), 0, "R5 epc sealed");
    acc(31, mk(1, 0, 0, 12'h444, 32'h0000_1008), 0, "R5 epc no exec");
    // R2: missing permission
    pcc_asr = 0;
    acc(30, mk(1, 0, 1, 12'hFFF, 32'hDEAD_BEEF), 0, "R2 denied");
    acc(30, '0, 1, "R2 unchanged after denial");
    // R1: index outside the file
    acc(27, mk(1, 0, 1, 12'hFFF, 32'h1234), 0, "R1 index 27");
    acc(0, mk(1, 0, 1, 12'hFFF, 32'h1234), 0, "R1 index 0");
    // R3: zero source keeps state, idle cycle outputs
    acc(29, mk(1, 0, 1, 12'h555, 32'h5555), 1, "R3 zero src");
    acc(29, '0, 1, "R3 still old");
    go("R3 idle");
    // R7: legacy CSR numbers
    csr_en = 1; csr_num = 12'h305; go("R7 legacy tvec");
    csr_en = 1; csr_num = 12'h341; go("R7 legacy epc");
    csr_en = 1; csr_num = 12'h300; go("R7 other csr");
    csr_en = 0; csr_num = 12'h305; go("R7 not enabled");
    // R9 R8: trap captures odd address, read returns it raw
    trap_wr = 1; trap_pc = 32'h0000_2001; go("R9 trap plain");
    acc(31, '0, 1, "R8 raw epc read");
    trap_wr = 1; trap_pc = 32'h0000_3000; trap_fetch_bounds = 1; go("R9 trap bounds");
    acc(31, '0, 1, "R9 bounds readback");
    trap_wr = 1; trap_pc = 32'h0000_4000;
    acc(31, mk(1, 0, 1, 12'h777, 32'h0000_5000), 0, "R9 trap beats write");
    acc(31, '0, 1, "R9 priority readback");
    // R10: reset reload
    acc(30, mk(0, 1, 1, 12'h0F0, 32'hABCD), 0, "R10 dirty scratch");
    rst_n = 0;
    @(negedge clk);
    rst_n = 1;
    mdl[0] = ROOT_EXEC; mdl[1] = ROOT_DATA; mdl[2] = ROOT_DATA; mdl[3] = ROOT_EXEC;
    for (int i = 28; i < 32; i++) acc(i, '0, 1, "R10 after reset");
    #5;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule